// File: doc/BRIEF.md
# Exhaustive Round-Robin Size Matcher

This block is the central half of a two-level cell scheduler for an input-queued switch with N inputs and N outputs. Each input reports a 2-bit occupancy code for every output. The code says whether the input has nothing for that output, at least one cell of any class, or more than one expedited cell. In every clock cycle, which is one cell slot, the block computes a maximal size matching between inputs and outputs. The result is a set of one-hot grant rows, one row per input. The per-input class choice that follows is handled elsewhere.

The matching runs a configurable number of request/grant/accept rounds, all inside one cycle. Each output keeps a grant pointer and each input keeps an accept pointer. When an accepted first-round grant goes to an input with an expedited backlog, the grant pointer stays on that input. That input is then favoured again in the next slot. Otherwise the grant pointer moves one place past the granted input. An accept pointer always lands on the output it accepted.

Top module: `rrx_size_matcher`

## Requirements
- R1: While `rst_n` is low at a rising edge, `grant_o` is cleared, the grant pointers load `GPTR_INIT` and the accept pointers load `APTR_INIT`. Field j of each vector belongs to port j, at bits [j*PW +: PW].
- R2: A grant bit i*N+j is set only if the occupancy code of input i for output j was nonzero in the slot that produced it.
- R3: Each input is granted at most one output, and each output is granted to at most one input.
- R4: In each round, an unmatched output grants the first requesting unmatched input, searching upward from its grant pointer with wrap-around. An unmatched input accepts the first granting output, searching upward from its accept pointer with wrap-around.
- R5: The grant pointer of output j changes only through a first-round grant that its input accepts. It moves to the granted input when that code has bit 1 set (code 2 or 3). Otherwise it moves to the granted input plus one, modulo N.
- R6: An input that is matched in any round sets its accept pointer to the matched output, not one past it.
- R7: A pointer keeps its value when its port issues no grant, when its grant is not accepted, or when its grant is accepted only in a later round.
- R8: Later rounds consider only pairs whose input and output are both still unmatched. With ITER >= N, the result is maximal: no requesting pair is left with both ends unmatched.
- R9: `grant_o` is registered. It reflects the `occ_i` sampled at the previous rising edge and holds steady between edges.
- R10: The code for input i and output j sits at `occ_i[(i*N+j)*2 +: 2]`: 0 means empty, 1 means any cell, 2 or 3 means expedited backlog. The grant for that pair is `grant_o[i*N+j]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one rising edge per cell slot |
| rst_n | input | 1 | Synchronous active-low reset |
| occ_i | input | 2*N*N | Occupancy codes for every input/output pair |
| grant_o | output | N*N | Matching result; row i is input i's one-hot grant vector |

## Verification
A wrong pointer leaves no mark on the slot in which it goes wrong. It shows only in the next slot in which two or more requesters compete for the same port, where a different input or output wins. The bench therefore drives sequences in which a contested slot directly follows the slot that moved the pointer. This exposes a wrong sticky rule, a wrong accept step or a spurious update within one cycle. A missed round or a stale free mask shows up at once as a non-maximal or doubly granted result.

// File: rtl/rrx_pkg.sv
// Shared constants and helpers for the round-robin size matcher.
// Assumes the 2-bit occupancy code layout described in the brief.
package rrx_pkg;
    localparam int CODE_W = 2;

    // A nonzero code means the pair takes part in matching.
    function automatic logic occ_requests(input logic [CODE_W-1:0] code);
        return code != '0;
    endfunction

    // Bit 1 set marks an expedited backlog, which keeps the grant pointer in place.
    function automatic logic occ_sticky(input logic [CODE_W-1:0] code);
        return code[1];
    endfunction
endpackage

// File: rtl/rrx_rr_pick.sv
// Round-robin picker: returns the first set request at or after ptr,
// wrapping modulo N. Purely combinational. Assumes ptr < N.
module rrx_rr_pick #(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [PW-1:0] ptr,
    output logic [N-1:0]  pick_oh,
    output logic [PW-1:0] pick_idx,
    output logic          pick_vld
);
    // Scan from farthest to nearest so the nearest requester wins.
    always_comb begin
        pick_oh  = '0;
        pick_idx = '0;
        pick_vld = 1'b0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[(int'(ptr) + k) % N]) begin
                pick_oh                        = '0;
                pick_oh[(int'(ptr) + k) % N]   = 1'b1;
                pick_idx                       = PW'((int'(ptr) + k) % N);
                pick_vld                       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rrx_match_round.sv
// One grant/accept round of the size matcher. Only pairs whose input and
// output are still free take part. Each output grants one input and each
// input accepts one grant. Combinational; pointers come from the caller.
module rrx_match_round #(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic [N*N-1:0]  req_mat,
    input  logic [N-1:0]    in_free,
    input  logic [N-1:0]    out_free,
    input  logic [N*PW-1:0] gptr,
    input  logic [N*PW-1:0] aptr,
    output logic [N*N-1:0]  pair_mat,
    output logic [N-1:0]    gnt_vld,
    output logic [N*PW-1:0] gnt_idx,
    output logic [N-1:0]    acc_vld,
    output logic [N*PW-1:0] acc_idx
);
    logic [N-1:0][N-1:0] col_req;   // [output][input]
    logic [N-1:0][N-1:0] gnt_oh;    // [output][input]
    logic [N-1:0][N-1:0] row_gnt;   // [input][output]
    logic [N-1:0][N-1:0] acc_oh;    // [input][output]

    // Wire the request, grant and accept matrices between the two arbiter banks.
    for (genvar gi = 0; gi < N; gi++) begin : g_row
        for (genvar gj = 0; gj < N; gj++) begin : g_col
            assign col_req[gj][gi]    = req_mat[gi*N+gj] & in_free[gi] & out_free[gj];
            assign row_gnt[gi][gj]    = gnt_oh[gj][gi];
            assign pair_mat[gi*N+gj]  = acc_oh[gi][gj];
        end
    end

    // Grant arbiters, one per output.
    for (genvar gj = 0; gj < N; gj++) begin : g_grant
        rrx_rr_pick #(.N(N), .PW(PW)) u_grant (
            .req      (col_req[gj]),
            .ptr      (gptr[gj*PW +: PW]),
            .pick_oh  (gnt_oh[gj]),
            .pick_idx (gnt_idx[gj*PW +: PW]),
            .pick_vld (gnt_vld[gj])
        );
    end

    // Accept arbiters, one per input.
    for (genvar gi = 0; gi < N; gi++) begin : g_accept
        rrx_rr_pick #(.N(N), .PW(PW)) u_accept (
            .req      (row_gnt[gi]),
            .ptr      (aptr[gi*PW +: PW]),
            .pick_oh  (acc_oh[gi]),
            .pick_idx (acc_idx[gi*PW +: PW]),
            .pick_vld (acc_vld[gi])
        );
    end
endmodule

// File: rtl/rrx_size_matcher.sv
// Central size matcher: ITER unrolled grant/accept rounds per clock,
// registered grant rows and round-robin pointers. Assumes every pointer
// init field is below N and that one clock is one cell slot.
module rrx_size_matcher
    import rrx_pkg::*;
#(
    parameter int N    = 4,
    parameter int ITER = 4,
    localparam int PW  = (N > 1) ? $clog2(N) : 1,
    parameter logic [N*PW-1:0] GPTR_INIT = '0,
    parameter logic [N*PW-1:0] APTR_INIT = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CODE_W*N*N-1:0] occ_i,
    output logic [N*N-1:0]        grant_o
);
    logic [N*N-1:0]             req_mat;
    logic [ITER:0][N-1:0]       in_free;
    logic [ITER:0][N-1:0]       out_free;
    logic [ITER-1:0][N*N-1:0]   pair_it;
    logic [ITER-1:0][N-1:0]     gv_it;
    logic [ITER-1:0][N-1:0]     av_it;
    logic [ITER-1:0][N*PW-1:0]  gi_it;
    logic [ITER-1:0][N*PW-1:0]  ai_it;
    logic [N*N-1:0]             pair_all;
    logic [N*N-1:0]             grant_q;
    logic [N*PW-1:0]            gptr_q, gptr_d;
    logic [N*PW-1:0]            aptr_q, aptr_d;

    // Decode each occupancy code into a request bit.
    for (genvar gk = 0; gk < N*N; gk++) begin : g_req
        assign req_mat[gk] = occ_requests(occ_i[gk*CODE_W +: CODE_W]);
    end

    assign in_free[0]  = '1;
    assign out_free[0] = '1;

    // Unrolled rounds; each one narrows the free masks for the next.
    for (genvar gt = 0; gt < ITER; gt++) begin : g_round
        logic [N-1:0] out_hit;

        rrx_match_round #(.N(N), .PW(PW)) u_round (
            .req_mat  (req_mat),
            .in_free  (in_free[gt]),
            .out_free (out_free[gt]),
            .gptr     (gptr_q),
            .aptr     (aptr_q),
            .pair_mat (pair_it[gt]),
            .gnt_vld  (gv_it[gt]),
            .gnt_idx  (gi_it[gt]),
            .acc_vld  (av_it[gt]),
            .acc_idx  (ai_it[gt])
        );

        // Mark outputs that found a partner in this round.
        always_comb begin
            out_hit = '0;
            for (int i = 0; i < N; i++) begin
                out_hit |= pair_it[gt][i*N +: N];
            end
        end

        assign in_free[gt+1]  = in_free[gt]  & ~av_it[gt];
        assign out_free[gt+1] = out_free[gt] & ~out_hit;
    end

    // Merge the pairs of all rounds into the slot's matching.
    always_comb begin
        pair_all = '0;
        for (int t = 0; t < ITER; t++) begin
            pair_all |= pair_it[t];
        end
    end

    // Grant pointers move only on an accepted first-round grant.
    always_comb begin
        gptr_d = gptr_q;
        for (int j = 0; j < N; j++) begin
            if (gv_it[0][j] && pair_it[0][int'(gi_it[0][j*PW +: PW])*N + j]) begin
                if (occ_sticky(occ_i[(int'(gi_it[0][j*PW +: PW])*N + j)*CODE_W +: CODE_W]))
                    gptr_d[j*PW +: PW] = gi_it[0][j*PW +: PW];
                else
                    gptr_d[j*PW +: PW] = PW'((int'(gi_it[0][j*PW +: PW]) + 1) % N);
            end
        end
    end

    // Accept pointers land on the output matched in whichever round.
    always_comb begin
        aptr_d = aptr_q;
        for (int t = 0; t < ITER; t++) begin
            for (int i = 0; i < N; i++) begin
                if (av_it[t][i]) aptr_d[i*PW +: PW] = ai_it[t][i*PW +: PW];
            end
        end
    end

    // Slot register: result and pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
            gptr_q  <= GPTR_INIT;
            aptr_q  <= APTR_INIT;
        end else begin
            grant_q <= pair_all;
            gptr_q  <= gptr_d;
            aptr_q  <= aptr_d;
        end
    end

    assign grant_o = grant_q;

    // ---------------- assertions ----------------
    logic [N-1:0][N-1:0] grant_col;   // [output][input]

    for (genvar gi = 0; gi < N; gi++) begin : g_chk_row
        for (genvar gj = 0; gj < N; gj++) begin : g_chk_col
            assign grant_col[gj][gi] = grant_o[gi*N+gj];

            a_r2_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && grant_o[gi*N+gj]) |-> ($past(occ_i[(gi*N+gj)*CODE_W +: CODE_W]) != '0));

            if (ITER >= N) begin : g_max
                a_r8_maximal: assert property (@(posedge clk) disable iff (!rst_n)
                    ($past(rst_n) && !(|grant_o[gi*N +: N]) && !(|grant_col[gj]))
                    |-> ($past(occ_i[(gi*N+gj)*CODE_W +: CODE_W]) == '0));
            end
        end

        a_r3_row_onehot: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant_o[gi*N +: N]));

        a_r3_col_onehot: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant_col[gi]));
    end
endmodule

// File: tb/rrx_size_matcher_bench.sv
`timescale 1ns/1ps
module rrx_size_matcher_bench;
    localparam int N    = 4;
    localparam int ITER = 4;
    localparam int PW   = 2;
    localparam int OW   = 2*N*N;
    // Initial pointers: grant g0..g3 = 0,2,2,1 ; accept a0..a3 = 1,3,2,0
    localparam logic [N*PW-1:0] GI = {2'd1, 2'd2, 2'd2, 2'd0};
    localparam logic [N*PW-1:0] AI = {2'd0, 2'd2, 2'd3, 2'd1};

    logic            clk = 1'b0;
    logic            rst_n;
    logic [OW-1:0]   occ;
    logic [N*N-1:0]  grant;
    logic [N*N-1:0]  prev_grant;

    int gp[N];
    int ap[N];
    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    rrx_size_matcher #(.N(N), .ITER(ITER), .GPTR_INIT(GI), .APTR_INIT(AI)) u_rrx_size_matcher (
        .clk(clk), .rst_n(rst_n), .occ_i(occ), .grant_o(grant)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic logic [OW-1:0] put(input logic [OW-1:0] v, input int i, input int j,
                                          input logic [1:0] c);
        v[(i*N+j)*2 +: 2] = c;
        return v;
    endfunction

    // Reference model of one slot: round-robin grant/accept rounds and pointer rules.
    task automatic model_slot(input logic [OW-1:0] ov, output logic [N*N-1:0] g);
        logic [N-1:0] in_m;
        logic [N-1:0] out_m;
        int gsel[N];
        int ngp[N];
        int nap[N];
        in_m  = '0;
        out_m = '0;
        g     = '0;
        for (int x = 0; x < N; x++) begin ngp[x] = gp[x]; nap[x] = ap[x]; end
        for (int it = 0; it < ITER; it++) begin
            for (int j = 0; j < N; j++) begin
                gsel[j] = -1;
                if (!out_m[j]) begin
                    for (int k = 0; k < N; k++) begin
                        int i;
                        i = (gp[j] + k) % N;
                        if (!in_m[i] && ov[(i*N+j)*2 +: 2] != 2'b00) begin
                            gsel[j] = i;
                            break;
                        end
                    end
                end
            end
            for (int i = 0; i < N; i++) begin
                if (!in_m[i]) begin
                    for (int k = 0; k < N; k++) begin
                        int j;
                        j = (ap[i] + k) % N;
                        if (gsel[j] == i) begin
                            g[i*N+j] = 1'b1;
                            in_m[i]  = 1'b1;
                            out_m[j] = 1'b1;
                            nap[i]   = j;
                            if (it == 0) ngp[j] = ov[(i*N+j)*2+1] ? i : (i + 1) % N;
                            break;
                        end
                    end
                end
            end
        end
        for (int x = 0; x < N; x++) begin gp[x] = ngp[x]; ap[x] = nap[x]; end
    endtask

    task automatic check_eq(input logic [N*N-1:0] act, input logic [N*N-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Structure checks: requested pairs only (R2), one-hot (R3), maximal (R8).
    task automatic check_struct(input logic [OW-1:0] ov, input logic [N*N-1:0] g);
        logic [N-1:0] rowm;
        logic [N-1:0] colm;
        int bad_req, bad_oh, bad_max;
        bad_req = 0; bad_oh = 0; bad_max = 0;
        rowm = '0; colm = '0;
        for (int i = 0; i < N; i++) begin
            int cnt;
            cnt = 0;
            for (int j = 0; j < N; j++) begin
                if (g[i*N+j]) begin
                    cnt++;
                    if (colm[j]) bad_oh++;
                    colm[j] = 1'b1;
                    rowm[i] = 1'b1;
                    if (ov[(i*N+j)*2 +: 2] == 2'b00) bad_req++;
                end
            end
            if (cnt > 1) bad_oh++;
        end
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (!rowm[i] && !colm[j] && ov[(i*N+j)*2 +: 2] != 2'b00) bad_max++;
        checks += 3;
        if (bad_req != 0) begin fails++; $display("FAIL R2 actual=%0d unrequested expected=0", bad_req); end
        if (bad_oh  != 0) begin fails++; $display("FAIL R3 actual=%0d conflicts expected=0", bad_oh); end
        if (bad_max != 0) begin fails++; $display("FAIL R8 actual=%0d free pairs expected=0", bad_max); end
    endtask

    // One slot: drive at negedge, verify hold before the edge (R9), compare after it.
    task automatic slot(input logic [OW-1:0] ov, input string tag, output logic [N*N-1:0] got);
        logic [N*N-1:0] exp;
        model_slot(ov, exp);
        prev_grant = grant;
        occ = ov;
        #1;
        check_eq(grant, prev_grant, "R9 hold before edge");
        @(posedge clk);
        @(negedge clk);
        got = grant;
        check_eq(got, exp, tag);
        check_struct(ov, got);
    endtask

    initial begin
        logic [OW-1:0]  ov;
        logic [N*N-1:0] got;
        void'($urandom(32'h5eed_1234));
        for (int x = 0; x < N; x++) begin
            gp[x] = int'(GI[x*PW +: PW]);
            ap[x] = int'(AI[x*PW +: PW]);
        end
        rst_n = 1'b0;
        occ   = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq(grant, '0, "R1 reset clears grants");
        rst_n = 1'b1;

        // R1: first slot exercises the configured initial pointers.
        ov = '0;
        ov = put(ov,0,0,2'd1); ov = put(ov,0,2,2'd1); ov = put(ov,0,3,2'd1);
        ov = put(ov,1,0,2'd2); ov = put(ov,1,1,2'd1); ov = put(ov,1,2,2'd1); ov = put(ov,1,3,2'd2);
        ov = put(ov,2,1,2'd1); ov = put(ov,2,2,2'd2); ov = put(ov,2,3,2'd1);
        for (int j = 0; j < N; j++) ov = put(ov,3,j,2'd1);
        slot(ov, "R1 R4 initial pointer slot", got);
        slot(ov, "R5 R6 follow-up slot", got);

        // R5 sticky grant pointer on expedited backlog; R10 bit positions.
        slot(put('0,1,0,2'd2), "R5 single expedited", got);
        check_eq(got, 16'h0010, "R10 pair (1,0) at bit 4");
        ov = put(put('0,1,0,2'd2),2,0,2'd1);
        slot(ov, "R5 sticky model", got);
        check_eq(got, 16'h0010, "R5 pointer stays on expedited input");
        ov = put(put('0,1,0,2'd1),2,0,2'd1);
        slot(ov, "R5 plain model", got);
        check_eq(got, 16'h0010, "R5 grant before step");
        slot(ov, "R5 plain step model", got);
        check_eq(got, 16'h0100, "R5 pointer steps past plain input");

        // R6 accept pointer lands on accepted output.
        slot(put('0,0,1,2'd1), "R6 setup", got);
        check_eq(got, 16'h0002, "R6 setup grant");
        slot(put(put('0,0,1,2'd1),0,2,2'd1), "R6 model", got);
        check_eq(got, 16'h0002, "R6 accept pointer on output not past it");

        // R7 unaccepted grant leaves the grant pointer alone.
        slot(put('0,3,0,2'd1), "R7 setup", got);
        check_eq(got, 16'h1000, "R7 setup grant");
        slot(put(put('0,3,0,2'd1),3,1,2'd1), "R7 model", got);
        check_eq(got, 16'h1000, "R7 one grant accepted");
        slot(put(put('0,0,1,2'd1),1,1,2'd1), "R7 model after", got);
        check_eq(got, 16'h0020, "R7 unaccepted grant kept pointer");

        // R4 R8: random patterns, dense and sparse, against the model.
        for (int n = 0; n < 400; n++) begin
            ov = '0;
            for (int k = 0; k < N*N; k++) begin
                int r;
                r = $urandom_range(0, (n % 3 == 0) ? 11 : 5);
                ov[k*2 +: 2] = (r < 2 || r > 5) ? 2'd0 : 2'(r - 2);
            end
            slot(ov, "R4 R8 random slot", got);
        end

        slot('0, "R2 idle slot", got);
        check_eq(got, '0, "R2 no requests no grants");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule